// File: doc/BRIEF.md
# Grouped Port Falling-Edge Interrupt Detector

This block watches an 8-pin input port and turns falling edges on selected pins into two sticky interrupt flags. The port is split into two groups of four pins: the low nibble (pins 0 to 3) feeds group flag 0, and the high nibble (pins 4 to 7) feeds group flag 1. Each pin has its own enable bit. Only enabled pins can act as interrupt sources, and only a high-to-low transition counts as an event.

Each raw pin first passes through a two-flop synchroniser. A history register then compares the previous synchronised level with the current one. When any enabled pin of a group falls, that group's flag is set. The flag stays set until software pulses the group's clear strobe. If a new edge and a clear land in the same cycle, the edge wins. Each group drives an interrupt request output that follows its flag.

After reset, detection is held off until the synchroniser and the history register have both loaded the real pin levels. A pin that is already low when reset is released therefore does not produce an edge.

Top module: `pin_fall_irq`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `flag_o` and `irq_o` are both 2'b00.
- R2: The level a pin holds while reset is released never creates an edge. With pins held at 8'h0F and all enables set through and after release, both flags stay 0.
- R3: A falling edge on an enabled pin among bits 0 to 3 of `pin_i` sets `flag_o[0]`. If the pin changes between clock edges, the flag is visible after the third rising edge that follows, and not after the second.
- R4: A falling edge on an enabled pin among bits 4 to 7 of `pin_i` sets `flag_o[1]`, with the same three-edge latency.
- R5: A rising edge on any pin never sets a flag.
- R6: A pin whose bit in `src_en_i` is 0 never sets a flag, no matter how often it toggles. Bit i of `src_en_i` enables bit i of `pin_i`.
- R7: A set flag holds until its clear strobe arrives. Bit g of `clr_i` clears `flag_o[g]` on the next rising edge and leaves the other group's flag unchanged.
- R8: If a group sees a qualifying edge in the same cycle as its clear strobe, its flag is 1 after that clock edge.
- R9: `irq_o[g]` equals `flag_o[g]` at all times.
- R10: Simultaneous falling edges on several pins set each affected group's flag once. Edges in both groups in the same cycle set both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 8 | Raw, asynchronous port pin levels |
| src_en_i | input | 8 | Per-pin interrupt source enable, bit i for pin i |
| clr_i | input | 2 | Per-group clear strobe, bit 0 for pins 0-3, bit 1 for pins 4-7 |
| flag_o | output | 2 | Sticky group flags |
| irq_o | output | 2 | Interrupt requests, one per group |

## Verification
A new falling edge can reach a group in the same cycle that software clears that group's flag. This is the collision that decides whether an event is lost. The bench first sets group 0 with one pin and then drops a second pin of the same group. It drives the clear strobe exactly in the cycle where the edge detector reports the second edge, two cycles after the pin change. It then expects the flag to still read 1 after that edge, and to read 0 only after a later clear that has no edge beside it. A second collision, two groups setting in the same cycle, is provoked by dropping pins of both nibbles at once and expecting both flags together.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int unsigned PFI_PINS_DEF   = 8;
  localparam int unsigned PFI_GRP_W_DEF  = 4;
  localparam int unsigned PFI_SYNC_DEF   = 2;
  localparam int unsigned PFI_RSYNC_DEF  = 2;

  // width of a counter able to hold values 0..n
  function automatic int unsigned pfi_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pfi_rst_sync.sv
module pfi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pfi_sync.sv
module pfi_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg_q [STAGES];

  // idle level of a pulled-up pin is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '1;
    else        stg_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfi_fall_det.sv
module pfi_fall_det
  import pfi_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned ARM_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] fall_o,
  output logic         armed_o
);
  localparam int unsigned CW = pfi_cnt_w(ARM_CYC);

  logic [W-1:0]  hist_q;
  logic [CW-1:0] arm_q;
  logic [CW-1:0] arm_d;
  logic          arm_en;
  logic          armed;

  always_comb begin
    armed  = (arm_q == CW'(ARM_CYC));
    arm_en = !armed;
    arm_d  = arm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_en) arm_q <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= lvl_i;
  end

  always_comb begin
    fall_o  = armed ? (hist_q & ~lvl_i & en_i) : '0;
    armed_o = armed;
  end
endmodule

// File: rtl/pfi_group_flag.sv
module pfi_group_flag #(
  parameter int unsigned GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] hit_i,
  input  logic          clr_i,
  output logic          set_o,
  output logic          flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    set_o   = |hit_i;
    flag_en = set_o | clr_i;
    // a fresh edge outranks a clear
    flag_d  = set_o | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_fall_irq.sv
module pin_fall_irq
  import pfi_pkg::*;
#(
  parameter int unsigned NUM_PINS    = PFI_PINS_DEF,
  parameter int unsigned GROUP_W     = PFI_GRP_W_DEF,
  parameter int unsigned SYNC_STAGES = PFI_SYNC_DEF,
  parameter int unsigned RST_STAGES  = PFI_RSYNC_DEF,
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PINS-1:0]   src_en_i,
  input  logic [NUM_GROUPS-1:0] clr_i,
  output logic [NUM_GROUPS-1:0] flag_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;

  logic                  rst_core_n;
  logic [NUM_PINS-1:0]   lvl;
  logic [NUM_PINS-1:0]   fall;
  logic [NUM_GROUPS-1:0] grp_set;
  logic                  armed;

  pfi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pfi_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .raw_i (pin_i),
    .lvl_o (lvl)
  );

  pfi_fall_det #(.W(NUM_PINS), .ARM_CYC(ARM_CYC)) u_det (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .lvl_i   (lvl),
    .en_i    (src_en_i),
    .fall_o  (fall),
    .armed_o (armed)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pfi_group_flag #(.GW(GROUP_W)) u_flag (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .hit_i  (fall[g*GROUP_W +: GROUP_W]),
      .clr_i  (clr_i[g]),
      .set_o  (grp_set[g]),
      .flag_o (flag_o[g])
    );
  end

  assign irq_o = flag_o;
endmodule

// File: rtl/pin_fall_irq_chk.sv
module pin_fall_irq_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned GROUP_W  = 4,
  localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   src_en_i,
  input logic [NUM_GROUPS-1:0] clr_i,
  input logic [NUM_GROUPS-1:0] flag_o,
  input logic [NUM_GROUPS-1:0] grp_set,
  input logic                  armed
);
  // R2
  arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (grp_set == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && clr_i[g] && !grp_set[g]) |=> !flag_o[g]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_set[g] |=> flag_o[g]);
    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o[g] && !grp_set[g]) |=> !flag_o[g]);
    // R6
    masked_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en_i[g*GROUP_W +: GROUP_W] == '0) |-> !grp_set[g]);
  end
endmodule

bind pin_fall_irq pin_fall_irq_chk #(.NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_en_i (src_en_i),
  .clr_i    (clr_i),
  .flag_o   (flag_o),
  .grp_set  (grp_set),
  .armed    (armed)
);

// File: tb/pin_fall_irq_tb.sv
module pin_fall_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pins;
  logic [7:0] en;
  logic [1:0] clr;
  logic [1:0] flag;
  logic [1:0] irq;

  always #5 clk = ~clk;

  pin_fall_irq u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pins),
    .src_en_i (en),
    .clr_i    (clr),
    .flag_o   (flag),
    .irq_o    (irq)
  );

  typedef struct {
    int         due;
    logic [1:0] exp;
    string      req;
  } item_t;

  item_t sbq[$];
  int    cyc    = 0;
  int    checks = 0;
  int    errors = 0;
  bit    ended  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic judge(input logic [1:0] exp, input string req);
    checks++;
    if (flag !== exp) begin
      errors++;
      $display("FAIL %s flag_o=%b expected %b (cycle %0d)", req, flag, exp, cyc);
    end
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL R9 (%s) irq_o=%b expected %b (cycle %0d)", req, irq, exp, cyc);
    end
  endtask

  // driver side: queue an expectation d cycles ahead
  task automatic expect_in(input int d, input logic [1:0] e, input string req);
    item_t it;
    it.due = cyc + d;
    it.exp = e;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare as results appear
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      judge(it.exp, it.req);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, flag_o=%b expected run end", flag);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pins  = 8'h0F;
    en    = 8'hFF;
    clr   = 2'b00;
    wait_cyc(3);
    judge(2'b00, "R1 in reset");
    rst_n = 1'b1;
    for (int d = 1; d <= 8; d++) expect_in(d, 2'b00, (d == 1) ? "R1 after release" : "R2 no false edge");
    wait_cyc(10);

    pins = 8'hFF;                       // rising edges on 4..7
    expect_in(3, 2'b00, "R5 rising ignored");
    expect_in(5, 2'b00, "R5 rising ignored");
    wait_cyc(6);

    pins = 8'hFB;                       // pin 2 falls
    expect_in(2, 2'b00, "R3 not yet at second edge");
    expect_in(3, 2'b01, "R3 group0 set");
    wait_cyc(4);
    pins = 8'hFF;
    expect_in(4, 2'b01, "R7 flag sticky");
    wait_cyc(5);

    clr = 2'b01;
    expect_in(1, 2'b00, "R7 clear group0");
    wait_cyc(1);
    clr = 2'b00;
    wait_cyc(2);

    pins = 8'hBF;                       // pin 6 falls
    expect_in(3, 2'b10, "R4 group1 set");
    wait_cyc(4);
    pins = 8'hFF;
    wait_cyc(3);
    clr = 2'b01;
    expect_in(1, 2'b10, "R7 other group kept");
    wait_cyc(1);
    clr = 2'b10;
    expect_in(1, 2'b00, "R7 clear group1");
    wait_cyc(1);
    clr = 2'b00;
    wait_cyc(3);

    en = 8'hEF;                         // pin 4 disabled
    for (int k = 0; k < 3; k++) begin
      pins = 8'hEF;
      expect_in(3, 2'b00, "R6 masked pin low");
      wait_cyc(2);
      pins = 8'hFF;
      expect_in(3, 2'b00, "R6 masked pin high");
      wait_cyc(2);
    end
    wait_cyc(4);
    en = 8'hFF;
    wait_cyc(2);

    pins = 8'hFD;                       // pin 1 falls, sets group0
    expect_in(3, 2'b01, "R3 pin1 set");
    wait_cyc(4);
    pins = 8'hFC;                       // pin 0 falls
    wait_cyc(2);
    clr = 2'b01;                        // same cycle as the detected edge
    expect_in(1, 2'b01, "R8 edge beats clear");
    wait_cyc(1);
    expect_in(1, 2'b00, "R8 later plain clear");
    wait_cyc(1);
    clr = 2'b00;
    pins = 8'hFF;
    wait_cyc(4);

    pins = 8'h66;                       // pins 0,3,4,7 fall together
    expect_in(3, 2'b11, "R10 both groups set");
    wait_cyc(4);
    pins = 8'hFF;
    clr = 2'b11;
    expect_in(1, 2'b00, "R10 both cleared");
    wait_cyc(1);
    clr = 2'b00;
    wait_cyc(4);
    finish_run();
  end
endmodule